// File: doc/BRIEF.md
# Multiplexed Eight-Digit Segment Display Driver

This block drives eight common-anode seven-segment digits that share one cathode bus. It takes a 64-bit word holding one raw 8-bit segment pattern per digit. It lights the digits one at a time, quickly enough that all eight appear to be on together. Because the patterns are raw, any symbol can be shown: hex digits, error marks or custom glyphs. A byte of all ones leaves its digit dark.

Each scan step has two phases. In the dark phase all anodes are off and the cathode bus is reloaded. In the lit phase the anode of the selected digit is driven. Both phases last one period of a scan tick. The tick comes from a counter on the system clock, and its period is a parameter: about 100000 gives roughly a kilohertz tick from a 100 MHz clock, and a testbench can use a small value. The digit index runs from 0 to 7 and then wraps.

Top module: `seg_mux_drv`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it rises, every bit of `anode_o` and `cathode_o` is 1. The first digit lit after reset is digit 0.
- R2: Digit d takes its pattern from `seg_word_i[(7-d)*8 +: 8]`, so digit 0 reads bits 63:56 and digit 7 reads bits 7:0. While digit d is lit, `cathode_o` equals that byte unchanged: bits 6:0 are segments a to g and bit 7 is the decimal point, all active low.
- R3: A pattern byte of 8'hFF keeps every cathode bit at 1 for the whole time its digit is lit.
- R4: In every cycle at most one bit of `anode_o` is 0. Lighting digit d drives exactly `anode_o[d]` to 0.
- R5: Digits are lit in the order 0, 1, ..., 7, then 0 again, with no digit skipped or repeated.
- R6: The lit and dark phases alternate. Each lasts exactly `TICK_DIV` clock cycles, with `TICK_DIV` of at least 2. Every lit phase is followed by a dark phase with all anodes at 1.
- R7: `cathode_o` changes only at a clock edge where `anode_o` is all ones both before and after that edge.
- R8: The cathode pattern for a digit is sampled from `seg_word_i` at the second clock edge of the dark phase before it. It then stays fixed through that digit's lit phase, even if `seg_word_i` changes while the digit is lit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| seg_word_i | input | 64 | Packed segment patterns, digit 0 in the top byte |
| cathode_o | output | 8 | Shared segment bus, active low (bit 7 decimal point) |
| anode_o | output | 8 | Digit enables, active low, bit d for digit d |

## Verification
Assertions check, on every cycle, the properties that involve one cycle or a neighbouring pair of cycles. These are: at most one anode is low, and a lit anode matches the current index. The cathodes move only with all anodes dark on both sides of the edge. The index advances only when a lit phase ends, ticks never come on back-to-back cycles, and the cathodes hold steady through a lit phase. Some behaviour needs knowledge of the input word over a whole scan: the byte packing, the wrap order, dark digits, the exact phase lengths, the fact that a word change in the middle of a lit phase does not tear the digit, and the restart at digit 0 after a reset during a scan. The bench's scoreboard covers these, comparing each lit phase with the byte it expects.

// File: rtl/seg_scan_pkg.sv
`timescale 1ns/1ps
package seg_scan_pkg;
  typedef enum logic {
    PH_DARK = 1'b0,
    PH_LIT  = 1'b1
  } scan_phase_e;
endpackage

// File: rtl/seg_tick_gen.sv
`timescale 1ns/1ps
module seg_tick_gen #(
  parameter int unsigned TICK_DIV = 100000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CNT_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TICK_DIV - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_q == CNT_LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick_o = (cnt_q == CNT_LAST);

  if (TICK_DIV > 1) begin : g_spaced
    AST_TICK_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_o |=> !tick_o); // R6
  end
endmodule

// File: rtl/seg_scan_seq.sv
`timescale 1ns/1ps
module seg_scan_seq
  import seg_scan_pkg::*;
#(
  parameter int unsigned NUM_DIG = 8,
  parameter int unsigned IDX_W   = $clog2(NUM_DIG)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output scan_phase_e      phase_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             load_o
);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_DIG - 1);

  scan_phase_e      phase_q;
  logic [IDX_W-1:0] idx_q;
  logic             load_q;
  logic [IDX_W-1:0] idx_nxt;

  assign idx_nxt = (idx_q == IDX_LAST) ? '0 : idx_q + 1'b1;

  // load_q marks the first cycle of each dark phase
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_DARK;
      idx_q   <= '0;
      load_q  <= 1'b1;
    end else begin
      load_q <= 1'b0;
      if (tick_i) begin
        if (phase_q == PH_DARK) begin
          phase_q <= PH_LIT;
        end else begin
          phase_q <= PH_DARK;
          idx_q   <= idx_nxt;
          load_q  <= 1'b1;
        end
      end
    end
  end

  assign phase_o = phase_q;
  assign idx_o   = idx_q;
  assign load_o  = load_q;

  AST_IDX_ON_DARK_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(idx_q) |-> (phase_q == PH_DARK && $past(phase_q) == PH_LIT)); // R5
  AST_LOAD_IN_DARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_q |-> phase_q == PH_DARK); // R8
endmodule

// File: rtl/seg_pat_sel.sv
`timescale 1ns/1ps
module seg_pat_sel #(
  parameter int unsigned NUM_DIG = 8,
  parameter int unsigned PAT_W   = 8,
  parameter int unsigned IDX_W   = $clog2(NUM_DIG)
) (
  input  logic [NUM_DIG*PAT_W-1:0] word_i,
  input  logic [IDX_W-1:0]         idx_i,
  output logic [PAT_W-1:0]         pat_o
);
  logic [PAT_W-1:0] slot [NUM_DIG];

  // digit 0 sits in the most significant byte
  for (genvar g = 0; g < NUM_DIG; g++) begin : g_slot
    assign slot[g] = word_i[(NUM_DIG-1-g)*PAT_W +: PAT_W];
  end

  assign pat_o = slot[idx_i];
endmodule

// File: rtl/seg_drive_out.sv
`timescale 1ns/1ps
module seg_drive_out
  import seg_scan_pkg::*;
#(
  parameter int unsigned NUM_DIG = 8,
  parameter int unsigned PAT_W   = 8,
  parameter int unsigned IDX_W   = $clog2(NUM_DIG)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  scan_phase_e        phase_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic               load_i,
  input  logic [PAT_W-1:0]   pat_i,
  output logic [PAT_W-1:0]   cathode_o,
  output logic [NUM_DIG-1:0] anode_o
);
  localparam logic [NUM_DIG-1:0] AN_ONE = NUM_DIG'(1);
  localparam logic [NUM_DIG-1:0] AN_OFF = '1;

  logic [PAT_W-1:0]   cath_q;
  logic [NUM_DIG-1:0] an_q;

  // anodes registered with the phase so they switch on the same edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cath_q <= '1;
      an_q   <= AN_OFF;
    end else begin
      if (load_i) cath_q <= pat_i;
      if (tick_i) an_q <= (phase_i == PH_DARK) ? ~(AN_ONE << idx_i) : AN_OFF;
    end
  end

  assign cathode_o = cath_q;
  assign anode_o   = an_q;

  AST_ONE_ANODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~an_q) <= 1); // R4
  AST_ANODE_IDX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (an_q != AN_OFF) |-> (an_q[idx_i] == 1'b0)); // R4
  AST_ANODE_LIT_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (an_q != AN_OFF) |-> (phase_i == PH_LIT)); // R6
  AST_CATH_DARK_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cath_q) |-> (an_q == AN_OFF && $past(an_q) == AN_OFF)); // R7
  AST_CATH_HOLD_LIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (an_q != AN_OFF && $past(an_q) != AN_OFF) |-> $stable(cath_q)); // R8
endmodule

// File: rtl/seg_mux_drv.sv
`timescale 1ns/1ps
module seg_mux_drv
  import seg_scan_pkg::*;
#(
  parameter int unsigned NUM_DIG  = 8,
  parameter int unsigned PAT_W    = 8,
  parameter int unsigned TICK_DIV = 100000
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_DIG*PAT_W-1:0] seg_word_i,
  output logic [PAT_W-1:0]         cathode_o,
  output logic [NUM_DIG-1:0]       anode_o
);
  localparam int unsigned IDX_W = $clog2(NUM_DIG);

  logic             tick;
  scan_phase_e      phase;
  logic [IDX_W-1:0] idx;
  logic             load;
  logic [PAT_W-1:0] pat;

  seg_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  seg_scan_seq #(.NUM_DIG(NUM_DIG), .IDX_W(IDX_W)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .phase_o(phase),
    .idx_o  (idx),
    .load_o (load)
  );

  seg_pat_sel #(.NUM_DIG(NUM_DIG), .PAT_W(PAT_W), .IDX_W(IDX_W)) u_sel (
    .word_i(seg_word_i),
    .idx_i (idx),
    .pat_o (pat)
  );

  seg_drive_out #(.NUM_DIG(NUM_DIG), .PAT_W(PAT_W), .IDX_W(IDX_W)) u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .phase_i  (phase),
    .idx_i    (idx),
    .load_i   (load),
    .pat_i    (pat),
    .cathode_o(cathode_o),
    .anode_o  (anode_o)
  );
endmodule

// File: tb/seg_mux_drv_tb.sv
`timescale 1ns/1ps
module seg_mux_drv_tb;
  localparam int DIV = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] seg_word_i = 64'h0123_4567_89AB_CDEF;
  logic [7:0]  cathode_o;
  logic [7:0]  anode_o;

  int total = 0;
  int bad = 0;
  logic [10:0] exp_q[$];
  event scan_end_ev;

  always #2.5 clk_i = ~clk_i;

  seg_mux_drv #(.NUM_DIG(8), .PAT_W(8), .TICK_DIV(DIV)) u_dut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .seg_word_i(seg_word_i),
    .cathode_o (cathode_o),
    .anode_o   (anode_o)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] byte_of(input logic [63:0] w, input int d);
    return w[(7-d)*8 +: 8];
  endfunction

  task automatic push_scan(input logic [63:0] w);
    for (int d = 0; d < 8; d++) exp_q.push_back({d[2:0], byte_of(w, d)});
  endtask

  // monitor: samples on the falling edge
  logic [7:0] prev_an = 8'hFF;
  logic [7:0] cur_pat = 8'hFF;
  int lit_len = 0;
  int dark_len = 0;
  bit first_lit = 1'b1;
  bit torn = 1'b0;

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      prev_an = 8'hFF;
      lit_len = 0;
      dark_len = 0;
      first_lit = 1'b1;
    end else begin
      chk($countones(~anode_o) <= 1, "R4 one anode", {56'h0, anode_o}, 64'h0);
      if (anode_o != 8'hFF) begin
        if (prev_an == 8'hFF) begin
          if (!first_lit) chk(dark_len == DIV, "R6 dark length", dark_len, DIV);
          first_lit = 1'b0;
          lit_len = 0;
          torn = 1'b0;
          if (exp_q.size() == 0) begin
            chk(1'b0, "R5 unexpected digit", {56'h0, anode_o}, 64'h0);
            cur_pat = cathode_o;
          end else begin
            logic [10:0] it;
            logic [7:0] exp_an;
            it = exp_q.pop_front();
            exp_an = ~(8'h01 << it[10:8]);
            chk(anode_o == exp_an, "R5 digit order / R4 anode bit", {56'h0, anode_o}, {56'h0, exp_an});
            chk(cathode_o == it[7:0], "R2 pattern", {56'h0, cathode_o}, {56'h0, it[7:0]});
            if (it[7:0] == 8'hFF) chk(cathode_o == 8'hFF, "R3 dark digit", {56'h0, cathode_o}, 64'hFF);
            cur_pat = it[7:0];
          end
        end
        lit_len++;
        if (cathode_o != cur_pat) torn = 1'b1;
      end else begin
        if (prev_an != 8'hFF) begin
          chk(lit_len == DIV, "R6 lit length", lit_len, DIV);
          chk(!torn, "R8 held pattern", {63'h0, torn}, 64'h0);
          dark_len = 0;
          if (prev_an == 8'h7F) -> scan_end_ev;
        end
        dark_len++;
      end
      prev_an = anode_o;
    end
  end

  task automatic apply(input logic [63:0] w);
    @(scan_end_ev);
    #1;
    seg_word_i = w;
    push_scan(w);
  endtask

  task automatic apply_mid(input logic [63:0] w_new);
    logic [63:0] w_old;
    @(scan_end_ev);
    #1;
    w_old = seg_word_i;
    for (int d = 0; d < 8; d++)
      exp_q.push_back({d[2:0], (d < 4) ? byte_of(w_old, d) : byte_of(w_new, d)});
    do @(negedge clk_i); while (anode_o != 8'hF7);
    #1;
    seg_word_i = w_new; // digit 3 is lit now and must keep the old byte
  endtask

  task automatic reset_mid(input logic [63:0] w);
    @(scan_end_ev);
    #1;
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk(anode_o == 8'hFF, "R1 anodes in reset", {56'h0, anode_o}, 64'hFF);
    chk(cathode_o == 8'hFF, "R1 cathodes in reset", {56'h0, cathode_o}, 64'hFF);
    chk(exp_q.size() == 0, "R5 scan complete before reset", exp_q.size(), 0);
    exp_q.delete();
    seg_word_i = w;
    push_scan(w); // R1: restart at digit 0
    @(negedge clk_i);
    #1;
    rst_ni = 1'b1;
  endtask

  initial begin
    push_scan(seg_word_i);
    repeat (3) @(negedge clk_i);
    chk(anode_o == 8'hFF, "R1 anodes after reset", {56'h0, anode_o}, 64'hFF);
    chk(cathode_o == 8'hFF, "R1 cathodes after reset", {56'h0, cathode_o}, 64'hFF);
    #1;
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(anode_o == 8'hFF, "R1 dark after release", {56'h0, anode_o}, 64'hFF);
    apply(64'hC0F9_A4B0_9992_9280);
    apply(64'hFF00_FF7E_FFFF_FF81); // R3 mixed dark digits
    apply(64'hFFFF_FFFF_FFFF_FFFF); // R3 all dark
    apply(64'h0000_0000_0000_0000);
    apply_mid(64'h1122_3344_5566_7788); // R8
    reset_mid(64'hA5A5_5A5A_3C3C_C3C3);  // R1
    apply(64'h7F7F_0102_0408_1020);
    @(scan_end_ev);
    chk(exp_q.size() == 0, "R5 all digits shown", exp_q.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule